// File: doc/BRIEF.md
# Black-Level Stabilization Line Sequencer

This block schedules the black-level measurement of a three-gun display tube and runs the tube warm-up sequence after switch-on. A vertical-blanking-end marker arms a window of four measurement lines, which are paced by a line strobe. The first line of the window measures leakage current. The next three lines each adjust one gun, in the fixed order red, green, blue.

Warm-up has several stages. Out of reset the RGB outputs are blanked, the beam-current limiter input is clamped, and stabilization is off. After a programmable wait, measuring pulses are driven on the measurement lines. The block then waits for an analog comparator to report that the sensed current is above the activation threshold. When that happens, stabilization starts. After a second programmable wait, blanking and the clamp are released and the block stays in normal operation.

The analog measurement and the hold capacitors are outside the block. They are represented here only by the comparator flag and the select outputs. Both waits are given as clock-cycle counts, so real-time values of roughly half a second and eight tenths of a second map onto the system clock.

Top module: `blk_stab_seq`

## Requirements
- R1: A pulse on `vb_end` arms the sequencer. The next `line_stb` opens a window of four measurement lines, numbered 0 to 3, and each later strobe advances one line. The strobe that follows line 3 closes the window. Strobes that arrive with no marker armed open no window.
- R2: While stabilization is enabled, `leak_meas` is high on line 0. `gun_adj` bit 0 (red), bit 1 (green) and bit 2 (blue) are high on lines 1, 2 and 3 respectively. At most one of these four selects is high at any time.
- R3: After reset, `rgb_blank` and `bcl_clamp` are 1, and `pulse_en`, `leak_meas` and `gun_adj` are 0.
- R4: `pulse_en` stays 0 until `WAIT_CYC` cycles after reset release. From then on it is high exactly during measurement lines.
- R5: Stabilization, meaning the selects of R2, becomes enabled only when `over_thresh` is high during a measurement line while pulses are enabled. `over_thresh` has no effect before the pulse stage begins, and it has no effect outside measurement lines.
- R6: `rgb_blank` and `bcl_clamp` stay 1 for `SETTLE_CYC` cycles after stabilization becomes enabled, then both drop to 0.
- R7: Once released, the block stays in normal operation. Blanking and clamp remain 0, every window drives pulses and selects, and `over_thresh` has no further effect.
- R8: A `vb_end` pulse that arrives while a window is open is ignored. It neither restarts nor extends the window, and it does not arm a following window.
- R9: Asserting `rst_n` during any stage returns the block to the state of R3 and restarts the warm-up from the beginning.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vb_end | input | 1 | One-cycle marker at the end of vertical blanking |
| line_stb | input | 1 | One-cycle strobe at the start of each line |
| over_thresh | input | 1 | Comparator flag: sensed current above the activation threshold |
| leak_meas | output | 1 | Leakage measurement select (line 0) |
| gun_adj | output | NUM_GUNS | Per-gun adjustment selects: bit 0 red, bit 1 green, bit 2 blue |
| rgb_blank | output | 1 | Blank the RGB outputs |
| bcl_clamp | output | 1 | Hold the beam-current limiter input shorted |
| pulse_en | output | 1 | Drive measuring pulses on the current line |

## Verification
The hardest condition to reach is the comparator flag arriving at exactly the right moment: after the pulse stage has begun, inside a measurement line. Earlier arrivals, and arrivals between windows, must leave stabilization off. To get there, the stimulus shortens both waits with small parameter values. It raises the flag once during a window in the initial wait, once between windows, and finally during the last line of a pulse-stage window. After each of these, a full window is replayed to show whether the selects turned on.

// File: rtl/bls_pkg.sv
package bls_pkg;
  typedef enum logic [1:0] {
    PH_WAIT   = 2'd0,
    PH_PROBE  = 2'd1,
    PH_SETTLE = 2'd2,
    PH_RUN    = 2'd3
  } bls_phase_e;
endpackage

// File: rtl/bls_rst_sync.sv
module bls_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/bls_line_seq.sv
module bls_line_seq #(
  parameter int NUM_GUNS = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            vb_end,
  input  logic                            line_stb,
  output logic                            win_active,
  output logic [$clog2(NUM_GUNS+1)-1:0]   line_idx
);
  localparam int LINES = NUM_GUNS + 1;
  localparam int IW    = $clog2(LINES);
  localparam logic [IW-1:0] LAST = IW'(LINES - 1);

  logic          armed_q, armed_n;
  logic          active_q, active_n;
  logic [IW-1:0] idx_q, idx_n;
  logic          upd_en;

  assign upd_en = vb_end | line_stb;

  always_comb begin
    armed_n  = armed_q;
    active_n = active_q;
    idx_n    = idx_q;
    if (vb_end && !active_q) armed_n = 1'b1;
    if (line_stb) begin
      if (active_q) begin
        if (idx_q == LAST) active_n = 1'b0;
        else               idx_n    = idx_q + 1'b1;
      end else if (armed_q) begin
        active_n = 1'b1;
        idx_n    = '0;
        armed_n  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      active_q <= 1'b0;
      idx_q    <= '0;
    end else if (upd_en) begin
      armed_q  <= armed_n;
      active_q <= active_n;
      idx_q    <= idx_n;
    end
  end

  assign win_active = active_q;
  assign line_idx   = idx_q;

  AST_WIN_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && line_stb && idx_q == LAST) |=> !active_q); // R1
  AST_WIN_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && !armed_q) |=> !active_q); // R1
  AST_MARK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !armed_q) |=> !armed_q); // R8
endmodule

// File: rtl/bls_cycle_timer.sv
module bls_cycle_timer #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] TOP = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          cnt_en;

  assign done   = run && (cnt_q == TOP);
  assign cnt_en = run ? !done : (cnt_q != '0);

  always_comb begin
    cnt_n = run ? cnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TOP); // R4
endmodule

// File: rtl/bls_warmup_ctl.sv
module bls_warmup_ctl
  import bls_pkg::*;
#(
  parameter int WAIT_CYC   = 1000,
  parameter int SETTLE_CYC = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       win_active,
  input  logic       over_thresh,
  output bls_phase_e phase
);
  bls_phase_e phase_q, phase_n;
  logic       wait_done, settle_done;
  logic       in_wait, in_settle;

  assign in_wait   = (phase_q == PH_WAIT);
  assign in_settle = (phase_q == PH_SETTLE);

  bls_cycle_timer #(.LIMIT(WAIT_CYC)) u_wait_tmr (
    .clk(clk), .rst_n(rst_n), .run(in_wait), .done(wait_done)
  );

  bls_cycle_timer #(.LIMIT(SETTLE_CYC)) u_settle_tmr (
    .clk(clk), .rst_n(rst_n), .run(in_settle), .done(settle_done)
  );

  always_comb begin
    phase_n = phase_q;
    unique case (phase_q)
      PH_WAIT:   if (wait_done)                  phase_n = PH_PROBE;
      PH_PROBE:  if (win_active && over_thresh)  phase_n = PH_SETTLE;
      PH_SETTLE: if (settle_done)                phase_n = PH_RUN;
      PH_RUN:                                    phase_n = PH_RUN;
      default:                                   phase_n = PH_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_WAIT;
    else        phase_q <= phase_n;
  end

  assign phase = phase_q;

  AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_RUN) |=> (phase_q == PH_RUN)); // R7
  AST_PROBE_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_PROBE && !(win_active && over_thresh)) |=> (phase_q == PH_PROBE)); // R5
  AST_WAIT_NO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_WAIT) |=> (phase_q == PH_WAIT || phase_q == PH_PROBE)); // R4
endmodule

// File: rtl/blk_stab_seq.sv
module blk_stab_seq
  import bls_pkg::*;
#(
  parameter int NUM_GUNS   = 3,
  parameter int WAIT_CYC   = 100000000,
  parameter int SETTLE_CYC = 160000000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                vb_end,
  input  logic                line_stb,
  input  logic                over_thresh,
  output logic                leak_meas,
  output logic [NUM_GUNS-1:0] gun_adj,
  output logic                rgb_blank,
  output logic                bcl_clamp,
  output logic                pulse_en
);
  localparam int IW = $clog2(NUM_GUNS + 1);

  logic          rst_n_sync;
  logic          win_active;
  logic [IW-1:0] line_idx;
  bls_phase_e    phase;
  logic          stab_en;
  logic          released;

  bls_rst_sync u_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync)
  );

  bls_line_seq #(.NUM_GUNS(NUM_GUNS)) u_line_seq (
    .clk(clk), .rst_n(rst_n_sync), .vb_end(vb_end), .line_stb(line_stb),
    .win_active(win_active), .line_idx(line_idx)
  );

  bls_warmup_ctl #(.WAIT_CYC(WAIT_CYC), .SETTLE_CYC(SETTLE_CYC)) u_warmup (
    .clk(clk), .rst_n(rst_n_sync), .win_active(win_active),
    .over_thresh(over_thresh), .phase(phase)
  );

  assign stab_en  = (phase == PH_SETTLE) || (phase == PH_RUN);
  assign released = (phase == PH_RUN);

  assign leak_meas = stab_en && win_active && (line_idx == '0);

  for (genvar g = 0; g < NUM_GUNS; g++) begin : g_gun_sel
    assign gun_adj[g] = stab_en && win_active && (line_idx == IW'(g + 1));
  end

  assign pulse_en  = win_active && (phase != PH_WAIT);
  assign rgb_blank = !released;
  assign bcl_clamp = !released;

  AST_ONE_SEL: assert property (@(posedge clk) disable iff (!rst_n_sync)
    $onehot0({leak_meas, gun_adj})); // R2
  AST_PULSE_IN_WIN: assert property (@(posedge clk) disable iff (!rst_n_sync)
    pulse_en |-> win_active); // R4
  AST_SEL_NEEDS_PULSE: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (leak_meas || (|gun_adj)) |-> pulse_en); // R5
  AST_RELEASE_FROM_SETTLE: assert property (@(posedge clk) disable iff (!rst_n_sync)
    $fell(rgb_blank) |-> $past(phase == PH_SETTLE)); // R6
endmodule

// File: tb/blk_stab_seq_tb_top.sv
`timescale 1ns/1ps
module blk_stab_seq_tb_top;
  localparam int NG     = 3;
  localparam int WAIT   = 40;
  localparam int SETTLE = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vb_end = 1'b0;
  logic line_stb = 1'b0;
  logic over_thresh = 1'b0;
  logic leak_meas, rgb_blank, bcl_clamp, pulse_en;
  logic [NG-1:0] gun_adj;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  blk_stab_seq #(.NUM_GUNS(NG), .WAIT_CYC(WAIT), .SETTLE_CYC(SETTLE)) dut_i (
    .clk(clk), .rst_n(rst_n), .vb_end(vb_end), .line_stb(line_stb),
    .over_thresh(over_thresh), .leak_meas(leak_meas), .gun_adj(gun_adj),
    .rgb_blank(rgb_blank), .bcl_clamp(bcl_clamp), .pulse_en(pulse_en)
  );

  // packed view: {blank, clamp, pulse, leak, gun[2:0]}
  function automatic logic [6:0] outs();
    return {rgb_blank, bcl_clamp, pulse_en, leak_meas, gun_adj};
  endfunction

  task automatic chk(input string req, input logic [6:0] exp);
    checks++;
    if (outs() !== exp) begin
      fails++;
      $display("FAIL %s: outputs {blank,clamp,pulse,leak,gun} act=%b exp=%b at %0t",
               req, outs(), exp, $time);
    end
  endtask

  task automatic strobe();
    line_stb = 1'b1;
    @(negedge clk);
    line_stb = 1'b0;
  endtask

  // one field: marker, four lines, closing strobe, extra strobe
  task automatic run_field(input string req, input bit stab, input bit pulse,
                           input bit blank, input bit thr_all,
                           input bit thr_last, input bit mark_mid);
    logic [6:0] exp;
    over_thresh = thr_all;
    vb_end = 1'b1;
    @(negedge clk);
    vb_end = 1'b0;
    repeat (2) @(negedge clk);
    for (int l = 0; l < 4; l++) begin
      strobe();
      exp = {blank, blank, pulse, (stab && l == 0) ? 1'b1 : 1'b0,
             (stab && l > 0) ? 3'(1 << (l - 1)) : 3'b000};
      chk(req, exp);
      if (mark_mid && l == 1) begin
        vb_end = 1'b1;
        @(negedge clk);
        vb_end = 1'b0;
        chk({req, " R8 marker mid-window"}, exp);
      end
      if (thr_last && l == 3) begin
        over_thresh = 1'b1;
        @(negedge clk);
        over_thresh = 1'b0;
      end
      repeat (2) @(negedge clk);
    end
    strobe();
    chk({req, " R1 window closed"}, {blank, blank, 5'b0});
    repeat (2) @(negedge clk);
    strobe();
    chk({req, " R1 R8 no rearm"}, {blank, blank, 5'b0});
    over_thresh = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset_state();
    chk("R3 reset state", 7'b1100000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R3 after release", 7'b1100000);
  endtask

  task automatic t_early_field();
    // flag high during the whole window in the initial wait: no effect
    run_field("R4 R5 early window", 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_probe_field();
    repeat (30) @(negedge clk);
    run_field("R4 R5 pulse stage", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_flag_between();
    over_thresh = 1'b1;
    repeat (5) @(negedge clk);
    over_thresh = 1'b0;
    run_field("R5 flag outside lines", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_no_marker();
    for (int i = 0; i < 3; i++) begin
      strobe();
      chk("R1 strobe without marker", 7'b1100000);
      @(negedge clk);
    end
  endtask

  task automatic t_activate();
    run_field("R5 activation window", 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    run_field("R2 R6 settle held", 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_released();
    repeat (SETTLE) @(negedge clk);
    chk("R6 released", 7'b0000000);
    run_field("R2 R7 normal", 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    run_field("R7 normal again", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_reset_mid();
    rst_n = 1'b0;
    #1;
    chk("R9 reset asserted", 7'b1100000);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 after reset", 7'b1100000);
    run_field("R9 restart wait", 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    t_early_field();
    t_probe_field();
    t_flag_between();
    t_no_marker();
    t_activate();
    t_released();
    t_reset_mid();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: act=timeout exp=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule